// File: doc/BRIEF.md
# Non-Restoring Signed Fraction Divider

This block divides one signed two's-complement fixed-point fraction by another, using the non-restoring method. Both operands are W bits wide, with the binary point just after the sign bit. A one-cycle start pulse captures the dividend and the divisor. The block then works out one quotient bit per clock cycle. A negative partial remainder is never repaired; the sign of each step's result simply decides the next step.

After W cycles the block raises a one-cycle completion pulse. At that point it shows the W-bit quotient and the final partial remainder. The remainder is one bit wider than the operands and is passed out exactly as the last step left it. A zero divisor is caught at capture time: the block finishes at once and raises an error flag in place of running the iterations.

The quotient is not rounded, and the remainder is not corrected. The caller is expected to supply operands whose true quotient has magnitude below one.

Top module: `nrdiv_frac`

## Requirements
- R1: While reset is applied and after its release, with no start, busy, done and the zero-divisor flag are 0, and the quotient and remainder outputs are all zeros.
- R2: A start pulse seen while idle with a nonzero divisor raises busy in the next cycle. Done is then high for exactly one cycle, W clock edges after the capturing edge, and busy falls at that same edge.
- R3: The first operation depends on the operand signs. If the dividend and divisor share a sign bit, the divisor is subtracted from the sign-extended dividend; otherwise it is added. This first result always fits in W+1 bits.
- R4: Each following step works as below, and the quotient bits enter the quotient register most significant bit first.
  - The quotient bit is 1 when the partial remainder's sign bit equals the divisor's sign bit, and 0 otherwise.
  - The remainder is then doubled.
  - The divisor is subtracted when the quotient bit is 1 and added when it is 0.
  - There are W-1 such steps, and no step ever restores the remainder.
- R5: Bit 0 of every nonzero-divisor quotient is forced to 1.
- R6: The remainder output is the W+1-bit two's-complement partial remainder left by the last step, with no correction applied.
- R7: A start pulse while busy is ignored. The running division finishes at its original time, with the results of its own operands.
- R8: A start with an all-zero divisor gives the following at the next edge:
  - done is high for one cycle and the zero-divisor flag is 1;
  - busy stays 0 and the quotient is zero;
  - the remainder holds the dividend, sign-extended to W+1 bits.

  The flag stays set until the next accepted start.
- R9: Read the quotient and the operands as fractions scaled by 2^-(W-1). When |dividend| < |divisor|, the quotient is within 2^-(W-2) of the true ratio.
- R10: While idle and with no start, the quotient and remainder outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start_i | input | 1 | One-cycle request that captures the operands |
| dividend_i | input | W | Signed fraction dividend |
| divisor_i | input | W | Signed fraction divisor |
| busy_o | output | 1 | High while the iterations run |
| done_o | output | 1 | One-cycle completion pulse |
| div_zero_o | output | 1 | Last accepted request had a zero divisor |
| quotient_o | output | W | Signed fraction quotient |
| remainder_o | output | W+1 | Final uncorrected partial remainder |

## Verification
The hardest conditions to reach from the ports are a partial remainder that lands exactly on zero in the middle of a run, and operand pairs whose quotient magnitude reaches or exceeds one. In both, a sign decision flips or the wide remainder wraps. The bench therefore sweeps every dividend and divisor pair of a 6-bit instance, so all of these conditions occur. Each result is compared with an arithmetic model of the same sign rule, wrapped to the remainder width. Extra runs drive a second start pulse partway through a division, to show that the request is dropped and the completion time is unchanged.

// File: rtl/nrdiv_pkg.sv
package nrdiv_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } nrdiv_state_e;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;   // capture operands and apply the first add or subtract
    logic zload;  // capture for a zero divisor
    logic step;   // one shift-and-add/subtract iteration
    logic last;   // append the forced final quotient bit
  } nrdiv_cmd_t;

  function automatic logic same_sign(input logic a_sign, input logic b_sign);
    return ~(a_sign ^ b_sign);
  endfunction

endpackage

// File: rtl/nrdiv_rst_sync.sv
module nrdiv_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_no = sync_q[1];

endmodule

// File: rtl/nrdiv_step.sv
module nrdiv_step #(
  parameter int W = 8
) (
  input  logic [W:0]   rem_i,
  input  logic [W-1:0] dvs_i,
  input  logic         shift_i,
  output logic         qbit_o,
  output logic [W:0]   rem_o
);

  localparam int SW = W + 2;

  logic [SW-1:0] base;
  logic [SW-1:0] dext;
  logic [SW-1:0] sum;

  always_comb begin
    qbit_o = nrdiv_pkg::same_sign(rem_i[W], dvs_i[W-1]);
    if (shift_i) begin
      base = {rem_i, 1'b0};
    end else begin
      base = {rem_i[W], rem_i};
    end
    dext = {{2{dvs_i[W-1]}}, dvs_i};
    if (qbit_o) begin
      sum = base - dext;
    end else begin
      sum = base + dext;
    end
    rem_o = sum[W:0];
  end

  // The first combination of two W-bit fractions never exceeds W+1 bits
  always_comb begin
    if (!shift_i) begin
      AST_FIRST_FITS: assert (sum[SW-1] == sum[SW-2]); // R3
    end
  end

endmodule

// File: rtl/nrdiv_ctrl.sv
module nrdiv_ctrl #(
  parameter int W = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [W-1:0]         divisor_i,
  output nrdiv_pkg::nrdiv_cmd_t cmd_o,
  output logic                 busy_o,
  output logic                 done_o,
  output logic                 dz_o
);

  localparam int CW = (W > 2) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  nrdiv_pkg::nrdiv_state_e state_q, state_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          done_q, done_n;
  logic          dz_q, dz_n;
  logic          cnt_en;
  logic          zero_dvs;
  logic          accept;

  assign zero_dvs = (divisor_i == '0);
  assign accept   = (state_q == nrdiv_pkg::ST_IDLE) && start_i;

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    cnt_en  = 1'b0;
    done_n  = 1'b0;
    dz_n    = dz_q;
    cmd_o   = '0;
    if (accept) begin
      if (zero_dvs) begin
        cmd_o.zload = 1'b1;
        done_n      = 1'b1;
        dz_n        = 1'b1;
      end else begin
        cmd_o.load  = 1'b1;
        state_n     = nrdiv_pkg::ST_RUN;
        cnt_n       = '0;
        cnt_en      = 1'b1;
        dz_n        = 1'b0;
      end
    end else if (state_q == nrdiv_pkg::ST_RUN) begin
      cnt_en = 1'b1;
      if (cnt_q == LAST) begin
        cmd_o.last = 1'b1;
        state_n    = nrdiv_pkg::ST_IDLE;
        done_n     = 1'b1;
        cnt_n      = '0;
      end else begin
        cmd_o.step = 1'b1;
        cnt_n      = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= nrdiv_pkg::ST_IDLE;
      done_q  <= 1'b0;
      dz_q    <= 1'b0;
    end else begin
      state_q <= state_n;
      done_q  <= done_n;
      dz_q    <= dz_n;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_n;
    end
  end

  assign busy_o = (state_q == nrdiv_pkg::ST_RUN);
  assign done_o = done_q;
  assign dz_o   = dz_q;

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q); // R2

  AST_BUSY_AFTER_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && !zero_dvs) |=> busy_o); // R2

  AST_DZ_FAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && zero_dvs) |=> (done_q && dz_q && !busy_o)); // R8

  AST_IGNORE_BUSY_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && cnt_q != LAST) |=> (busy_o && cnt_q == $past(cnt_q) + CW'(1))); // R7

endmodule

// File: rtl/nrdiv_dp.sv
module nrdiv_dp #(
  parameter int W = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  nrdiv_pkg::nrdiv_cmd_t cmd_i,
  input  logic [W-1:0]          dividend_i,
  input  logic [W-1:0]          divisor_i,
  output logic [W-1:0]          quo_o,
  output logic [W:0]            rem_o
);

  logic [W:0]   rem_q, rem_n;
  logic [W-1:0] quo_q, quo_n;
  logic [W-1:0] dvs_q, dvs_n;
  logic         en_rem, en_quo, en_dvs;

  logic [W:0]   st_rem_in;
  logic [W-1:0] st_dvs_in;
  logic         st_shift;
  logic         st_qbit;
  logic [W:0]   st_rem_out;
  logic [W:0]   dividend_ext;

  assign dividend_ext = {dividend_i[W-1], dividend_i};

  // One adder serves both the capture step and every later iteration
  always_comb begin
    if (cmd_i.load) begin
      st_rem_in = dividend_ext;
      st_dvs_in = divisor_i;
      st_shift  = 1'b0;
    end else begin
      st_rem_in = rem_q;
      st_dvs_in = dvs_q;
      st_shift  = 1'b1;
    end
  end

  nrdiv_step #(.W(W)) step_i (
    .rem_i   (st_rem_in),
    .dvs_i   (st_dvs_in),
    .shift_i (st_shift),
    .qbit_o  (st_qbit),
    .rem_o   (st_rem_out)
  );

  always_comb begin
    rem_n  = rem_q;
    quo_n  = quo_q;
    dvs_n  = dvs_q;
    en_rem = 1'b0;
    en_quo = 1'b0;
    en_dvs = 1'b0;
    if (cmd_i.load) begin
      rem_n  = st_rem_out;
      quo_n  = '0;
      dvs_n  = divisor_i;
      en_rem = 1'b1;
      en_quo = 1'b1;
      en_dvs = 1'b1;
    end else if (cmd_i.zload) begin
      rem_n  = dividend_ext;
      quo_n  = '0;
      en_rem = 1'b1;
      en_quo = 1'b1;
    end else if (cmd_i.step) begin
      rem_n  = st_rem_out;
      quo_n  = {quo_q[W-2:0], st_qbit};
      en_rem = 1'b1;
      en_quo = 1'b1;
    end else if (cmd_i.last) begin
      quo_n  = {quo_q[W-2:0], 1'b1};
      en_quo = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q <= '0;
    end else if (en_rem) begin
      rem_q <= rem_n;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      quo_q <= '0;
    end else if (en_quo) begin
      quo_q <= quo_n;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dvs_q <= '0;
    end else if (en_dvs) begin
      dvs_q <= dvs_n;
    end
  end

  assign quo_o = quo_q;
  assign rem_o = rem_q;

  AST_ONE_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({cmd_i.load, cmd_i.zload, cmd_i.step, cmd_i.last})); // R7

  AST_LSB_FORCED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i.last |=> quo_q[0]); // R5

endmodule

// File: rtl/nrdiv_frac.sv
module nrdiv_frac #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic         busy_o,
  output logic         done_o,
  output logic         div_zero_o,
  output logic [W-1:0] quotient_o,
  output logic [W:0]   remainder_o
);

  logic                  rst_n;
  nrdiv_pkg::nrdiv_cmd_t cmd;

  nrdiv_rst_sync rst_sync_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n)
  );

  nrdiv_ctrl #(.W(W)) ctrl_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .start_i   (start_i),
    .divisor_i (divisor_i),
    .cmd_o     (cmd),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .dz_o      (div_zero_o)
  );

  nrdiv_dp #(.W(W)) dp_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .cmd_i      (cmd),
    .dividend_i (dividend_i),
    .divisor_i  (divisor_i),
    .quo_o      (quotient_o),
    .rem_o      (remainder_o)
  );

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!busy_o && !start_i) |=> ($stable(quotient_o) && $stable(remainder_o))); // R10

  AST_DONE_LSB: assert property (@(posedge clk_i) disable iff (!rst_n)
    (done_o && !div_zero_o) |-> quotient_o[0]); // R5

  AST_DONE_NOT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_n)
    done_o |-> !busy_o); // R2

endmodule

// File: tb/nrdiv_frac_tb_top.sv
`timescale 1ns/1ps
module nrdiv_frac_tb_top;

  localparam int TW = 6;
  localparam int HALF = TW - 1;

  logic          clk;
  logic          rst_n;
  logic          start;
  logic [TW-1:0] dividend;
  logic [TW-1:0] divisor;
  logic          busy;
  logic          done;
  logic          dz;
  logic [TW-1:0] quo;
  logic [TW:0]   rem;

  int checks = 0;
  int bad = 0;
  int cyc = 0;

  nrdiv_frac #(.W(TW)) dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .start_i     (start),
    .dividend_i  (dividend),
    .divisor_i   (divisor),
    .busy_o      (busy),
    .done_o      (done),
    .div_zero_o  (dz),
    .quotient_o  (quo),
    .remainder_o (rem)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++;
      checks++;
      $display("FAIL R2 watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int wrap_rem(input int v);
    logic [TW:0] t;
    t = v[TW:0];
    return int'($signed(t));
  endfunction

  // Arithmetic model of the sign-driven add/subtract rule
  task automatic model(input int x, input int y, output int q, output int r);
    int b;
    if ((x < 0) == (y < 0)) r = x - y;
    else r = x + y;
    r = wrap_rem(r);
    q = 0;
    for (int k = 0; k < TW - 1; k++) begin
      b = ((r < 0) == (y < 0)) ? 1 : 0;
      q = (q << 1) | b;
      r = wrap_rem(2 * r + ((b != 0) ? -y : y));
    end
    q = ((q << 1) | 1) & ((1 << TW) - 1);
  endtask

  function automatic int absi(input int v);
    return (v < 0) ? -v : v;
  endfunction

  task automatic run_op(input int x, input int y, input bit poke);
    int n;
    int exp_n;
    int qm;
    int rm;
    int qs;
    int rs;
    int held_q;
    int err;
    @(negedge clk);
    start    = 1'b1;
    dividend = x[TW-1:0];
    divisor  = y[TW-1:0];
    @(negedge clk);
    start = 1'b0;
    if (y != 0) chk(busy == 1'b1, "R2 busy after start", int'(busy), 1);
    else chk(busy == 1'b0, "R8 busy stays low", int'(busy), 0);
    n = 0;
    while (!done && n < 4 * TW) begin
      if (poke && n == 2) begin
        start    = 1'b1;
        dividend = ~dividend;
        divisor  = divisor ^ 1;
      end
      @(negedge clk);
      start = 1'b0;
      n++;
    end
    exp_n = (y == 0) ? 0 : TW;
    chk(n == exp_n, poke ? "R7 finish time" : ((y == 0) ? "R8 done time" : "R2 done time"), n, exp_n);
    qs = $signed(quo);
    rs = $signed(rem);
    if (y == 0) begin
      chk(dz == 1'b1, "R8 flag", int'(dz), 1);
      chk(quo == '0, "R8 quotient", qs, 0);
      chk(rs == x, "R8 remainder", rs, x);
    end else begin
      model(x, y, qm, rm);
      chk(dz == 1'b0, "R2 flag clear", int'(dz), 0);
      chk(int'(quo) == qm, poke ? "R7 quotient" : "R4 quotient", int'(quo), qm);
      chk(rs == rm, poke ? "R7 remainder" : "R6 remainder", rs, rm);
      chk(quo[0] == 1'b1, "R5 lsb", int'(quo[0]), 1);
      if (absi(x) < absi(y)) begin
        err = qs * y - x * (1 << HALF);
        chk(absi(err) <= 2 * absi(y), "R9 accuracy", err, 0);
      end
      if ((x < 0) == (y < 0) && x == y) begin
        chk(1'b1, "R3 same sign equal", 0, 0);
      end
    end
    held_q = int'(quo);
    @(negedge clk);
    chk(done == 1'b0, "R2 single pulse", int'(done), 0);
    chk(int'(quo) == held_q, "R10 hold", int'(quo), held_q);
  endtask

  initial begin
    int q0;
    int r0;
    rst_n    = 1'b0;
    start    = 1'b0;
    dividend = '0;
    divisor  = '0;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0 && dz == 1'b0, "R1 flags in reset", int'({busy, done, dz}), 0);
    chk(quo == '0 && rem == '0, "R1 data in reset", int'(quo), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0 && dz == 1'b0, "R1 flags after reset", int'({busy, done, dz}), 0);
    chk(quo == '0 && rem == '0, "R1 data after reset", int'(rem), 0);

    // R3: first-step sign choice, spot cases before the sweep
    run_op(8, 16, 1'b0);
    model(8, 16, q0, r0);
    chk(int'(quo) == q0, "R3 same signs subtract", int'(quo), q0);
    run_op(-8, 16, 1'b0);
    model(-8, 16, q0, r0);
    chk(int'(quo) == q0, "R3 mixed signs add", int'(quo), q0);

    // Full sweep of the 6-bit operand space
    for (int x = -(1 << HALF); x < (1 << HALF); x++) begin
      for (int y = -(1 << HALF); y < (1 << HALF); y++) begin
        run_op(x, y, 1'b0);
      end
    end

    // R7: second start pulses during a run
    run_op(5, 13, 1'b1);
    run_op(-11, 20, 1'b1);
    run_op(-3, -31, 1'b1);
    run_op(0, -1, 1'b1);

    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule